// File: doc/BRIEF.md
# Chip-Select Access-Violation Status Unit

This block sits next to an external-bus chip-select decoder and watches every decoded access to one of up to eight chip-select regions. Each region has two attribute inputs: a read-only flag and a write-only flag. An access that goes against its region's attribute is a violation. A read of a write-only region sets one sticky error flag. A write to a read-only region sets the other. Each violation also records the number of the offending region, and that number is replaced by the region of the most recent violation. Software clears a flag by writing 1 to its bit position.

The block also decides whether each decoded access is accepted. A global master enable gates all regions. The exception is region 0 while it serves as the boot device: in that case only its own boot enable decides. Violating accesses are always rejected. Violation detection does not depend on the master enable, the boot enable or any bus-error setting, so a violation is flagged even when the access is refused for other reasons.

The register port has two words, selected by `reg_addr_i`: the status word (address 0) and the control word (address 1). Reads are combinational and writes take effect at the next clock edge. The register port keeps working whatever the master enable holds.

Top module: `cs_viol_status`

## Requirements
- R1: A valid read (`acc_wr_i`=0) to region i with `wo_attr_i[i]`=1 sets the write-only error flag, which reads back at status bit 29 (lsb-0 numbering) from the next cycle on.
- R2: A valid write (`acc_wr_i`=1) to region i with `ro_attr_i[i]`=1 sets the read-only error flag, which reads back at status bit 28 from the next cycle on.
- R3: Both flags are sticky. A status write (address 0) with 1 in bit 29 or bit 28 clears that flag at the next edge. A write with 0 in a flag's bit leaves that flag unchanged.
- R4: Status bits 26:24 hold the region number (0 to 7) of the most recent violation. A later violation overwrites it, even while a flag is already set.
- R5: If a violation sets a flag in the same cycle that software writes 1 to clear it, the flag ends up set.
- R6: Violations are detected and recorded even when the access is rejected because the master or boot enable is 0.
- R7: The control word holds the master enable in bit 0, the boot enable in bit 1 and the boot-active bit in bit 2. While the master enable is 0, `acc_ok_o` stays 0 for every region other than a boot region 0, and register reads and writes still take effect.
- R8: While boot-active is 1, an access to region 0 is accepted exactly when the boot enable is 1, whatever the master enable holds. While boot-active is 0, region 0 follows the master enable like any other region.
- R9: `acc_ok_o` is 1 only for a valid, non-violating access to a region that is enabled, and it is combinational in the same cycle as the access.
- R10: After reset the status word reads 0. The control word reads 6 (boot-active=1, boot enable=1, master enable=0). All unused bits of both words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Word select: 0 = status, 1 = control |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected word |
| acc_valid_i | input | 1 | A decoded external access is present |
| acc_cs_i | input | 3 | Region number of the access |
| acc_wr_i | input | 1 | Access direction: 1 = write, 0 = read |
| ro_attr_i | input | 8 | Per-region read-only attribute |
| wo_attr_i | input | 8 | Per-region write-only attribute |
| acc_ok_o | output | 1 | The access is accepted |

## Verification
The hardest case to reach is a violation that lands in the same cycle as a write-one-clear of the same flag, because the register port and the access port have to line up on one edge. The bench drives a status write with the clear bit together with a violating access in a single step. It does the same with a region-0 access while boot-active is set and the master enable is off, which shows that the gating is separate from the detection. A pseudo-random run then mixes accesses, clears and control writes, and a behavioural model is compared against both outputs every cycle.

// File: rtl/cs_viol_pkg.sv
package cs_viol_pkg;
  localparam int unsigned DATA_W       = 32;
  // status word bit positions (lsb-0)
  localparam int unsigned STAT_WO_BIT  = 29;
  localparam int unsigned STAT_RO_BIT  = 28;
  localparam int unsigned STAT_IDX_LSB = 24;
  // control word bit positions
  localparam int unsigned CTRL_MEN_BIT  = 0;
  localparam int unsigned CTRL_BEN_BIT  = 1;
  localparam int unsigned CTRL_BACT_BIT = 2;

  typedef struct packed {
    logic boot_act;
    logic boot_en;
    logic mst_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{boot_act: 1'b1, boot_en: 1'b1, mst_en: 1'b0};
endpackage

// File: rtl/cs_viol_detect.sv
module cs_viol_detect #(
  parameter int unsigned N_REGIONS = 8,
  localparam int unsigned IDX_W    = $clog2(N_REGIONS)
) (
  input  logic                 valid_i,
  input  logic [IDX_W-1:0]     cs_i,
  input  logic                 wr_i,
  input  logic [N_REGIONS-1:0] ro_attr_i,
  input  logic [N_REGIONS-1:0] wo_attr_i,
  output logic                 wo_viol_o,
  output logic                 ro_viol_o
);
  logic [N_REGIONS-1:0] hit;

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_hit
    assign hit[g] = valid_i && (cs_i == IDX_W'(g));
  end

  assign wo_viol_o = !wr_i && |(hit & wo_attr_i);
  assign ro_viol_o =  wr_i && |(hit & ro_attr_i);
endmodule

// File: rtl/cs_access_gate.sv
module cs_access_gate
  import cs_viol_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             valid_i,
  input  logic [IDX_W-1:0] cs_i,
  input  logic             viol_i,
  input  ctrl_t            ctrl_i,
  output logic             ok_o
);
  logic boot_path;
  logic open;

  // region 0 as boot device bypasses the master enable
  assign boot_path = ctrl_i.boot_act && (cs_i == '0);
  assign open      = boot_path ? ctrl_i.boot_en : ctrl_i.mst_en;
  assign ok_o      = valid_i && open && !viol_i;
endmodule

// File: rtl/cs_ctrl_reg.sv
module cs_ctrl_reg
  import cs_viol_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= CTRL_RST;
    end else if (we_i) begin
      ctrl_o.mst_en   <= wdata_i[CTRL_MEN_BIT];
      ctrl_o.boot_en  <= wdata_i[CTRL_BEN_BIT];
      ctrl_o.boot_act <= wdata_i[CTRL_BACT_BIT];
    end
  end
endmodule

// File: rtl/cs_status_regs.sv
module cs_status_regs #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_wo_i,
  input  logic             clr_ro_i,
  input  logic             set_wo_i,
  input  logic             set_ro_i,
  input  logic [IDX_W-1:0] cs_i,
  output logic             wo_o,
  output logic             ro_o,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wo_o  <= 1'b0;
      ro_o  <= 1'b0;
      idx_o <= '0;
    end else begin
      // set dominates clear
      wo_o <= set_wo_i || (wo_o && !clr_wo_i);
      ro_o <= set_ro_i || (ro_o && !clr_ro_i);
      if (set_wo_i || set_ro_i) idx_o <= cs_i;
    end
  end
endmodule

// File: rtl/cs_viol_status.sv
module cs_viol_status
  import cs_viol_pkg::*;
#(
  parameter int unsigned N_REGIONS = 8,
  localparam int unsigned IDX_W    = $clog2(N_REGIONS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic                 reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic                 acc_valid_i,
  input  logic [IDX_W-1:0]     acc_cs_i,
  input  logic                 acc_wr_i,
  input  logic [N_REGIONS-1:0] ro_attr_i,
  input  logic [N_REGIONS-1:0] wo_attr_i,
  output logic                 acc_ok_o
);
  logic             wo_viol, ro_viol;
  logic             wo_flag, ro_flag;
  logic [IDX_W-1:0] err_idx;
  ctrl_t            ctrl_q;
  logic             stat_we, ctrl_we;
  logic             unused_wdata;

  assign stat_we = reg_we_i && (reg_addr_i == 1'b0);
  assign ctrl_we = reg_we_i && (reg_addr_i == 1'b1);
  assign unused_wdata = ^reg_wdata_i;

  cs_viol_detect #(.N_REGIONS(N_REGIONS)) u_detect (
    .valid_i   (acc_valid_i),
    .cs_i      (acc_cs_i),
    .wr_i      (acc_wr_i),
    .ro_attr_i (ro_attr_i),
    .wo_attr_i (wo_attr_i),
    .wo_viol_o (wo_viol),
    .ro_viol_o (ro_viol)
  );

  cs_status_regs #(.IDX_W(IDX_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_wo_i (stat_we && reg_wdata_i[STAT_WO_BIT]),
    .clr_ro_i (stat_we && reg_wdata_i[STAT_RO_BIT]),
    .set_wo_i (wo_viol),
    .set_ro_i (ro_viol),
    .cs_i     (acc_cs_i),
    .wo_o     (wo_flag),
    .ro_o     (ro_flag),
    .idx_o    (err_idx)
  );

  cs_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl_q)
  );

  cs_access_gate #(.IDX_W(IDX_W)) u_gate (
    .valid_i (acc_valid_i),
    .cs_i    (acc_cs_i),
    .viol_i  (wo_viol || ro_viol),
    .ctrl_i  (ctrl_q),
    .ok_o    (acc_ok_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == 1'b0) begin
      reg_rdata_o[STAT_WO_BIT]             = wo_flag;
      reg_rdata_o[STAT_RO_BIT]             = ro_flag;
      reg_rdata_o[STAT_IDX_LSB +: IDX_W]   = err_idx;
    end else begin
      reg_rdata_o[CTRL_MEN_BIT]  = ctrl_q.mst_en;
      reg_rdata_o[CTRL_BEN_BIT]  = ctrl_q.boot_en;
      reg_rdata_o[CTRL_BACT_BIT] = ctrl_q.boot_act;
    end
  end
endmodule

// File: rtl/cs_viol_chk.sv
module cs_viol_chk
  import cs_viol_pkg::*;
#(
  parameter int unsigned N_REGIONS = 8,
  localparam int unsigned IDX_W    = $clog2(N_REGIONS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic                 reg_addr_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic                 acc_valid_i,
  input logic [IDX_W-1:0]     acc_cs_i,
  input logic                 acc_wr_i,
  input logic [N_REGIONS-1:0] ro_attr_i,
  input logic [N_REGIONS-1:0] wo_attr_i,
  input logic                 acc_ok_o,
  input logic                 wo_flag,
  input logic                 ro_flag,
  input logic [IDX_W-1:0]     err_idx,
  input ctrl_t                ctrl_q
);
  logic rd_viol, wr_viol;
  assign rd_viol = acc_valid_i && !acc_wr_i && wo_attr_i[acc_cs_i];
  assign wr_viol = acc_valid_i &&  acc_wr_i && ro_attr_i[acc_cs_i];

  // R1
  wo_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_viol |=> wo_flag);
  // R2
  ro_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_viol |=> ro_flag);
  // R3
  wo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wo_flag && !(reg_we_i && !reg_addr_i && reg_wdata_i[STAT_WO_BIT])) |=> wo_flag);
  // R3
  ro_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ro_flag && !(reg_we_i && !reg_addr_i && reg_wdata_i[STAT_RO_BIT])) |=> ro_flag);
  // R4
  idx_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_viol || wr_viol) |=> err_idx == $past(acc_cs_i));
  // R7
  mst_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.mst_en && !(ctrl_q.boot_act && acc_cs_i == '0)) |-> !acc_ok_o);
  // R9
  viol_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_viol || wr_viol || !acc_valid_i) |-> !acc_ok_o);
endmodule

bind cs_viol_status cs_viol_chk #(.N_REGIONS(N_REGIONS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .acc_valid_i (acc_valid_i),
  .acc_cs_i    (acc_cs_i),
  .acc_wr_i    (acc_wr_i),
  .ro_attr_i   (ro_attr_i),
  .wo_attr_i   (wo_attr_i),
  .acc_ok_o    (acc_ok_o),
  .wo_flag     (wo_flag),
  .ro_flag     (ro_flag),
  .err_idx     (err_idx),
  .ctrl_q      (ctrl_q)
);

// File: tb/cs_viol_status_test.sv
module cs_viol_status_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        v = 1'b0;
  logic [2:0]  cs = '0;
  logic        wr = 1'b0;
  logic [7:0]  ro_a = 8'b0010_0000;
  logic [7:0]  wo_a = 8'b1000_0100;
  logic        ok;

  int tests = 0;
  int fails = 0;

  // reference model state
  bit       m_wo, m_ro, m_men, m_ben, m_bact;
  bit [2:0] m_idx;

  always #(PERIOD/2) clk = ~clk;

  cs_viol_status uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .acc_valid_i(v),
    .acc_cs_i(cs), .acc_wr_i(wr), .ro_attr_i(ro_a), .wo_attr_i(wo_a),
    .acc_ok_o(ok)
  );

  function automatic logic [31:0] exp_rdata(bit a);
    logic [31:0] r = '0;
    if (!a) begin
      r[29] = m_wo; r[28] = m_ro; r[26:24] = m_idx;
    end else begin
      r[0] = m_men; r[1] = m_ben; r[2] = m_bact;
    end
    return r;
  endfunction

  function automatic bit exp_ok();
    bit viol = v && (wr ? ro_a[cs] : wo_a[cs]);
    bit open = (m_bact && cs == 0) ? m_ben : m_men;
    return v && open && !viol;
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdata actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: acc_ok actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit w, bit a, logic [31:0] d,
                      bit vv, bit [2:0] c, bit ww);
    bit sw, sr, cw, cr;
    we = w; addr = a; wdata = d; v = vv; cs = c; wr = ww;
    #1;
    check32(tag, rdata, exp_rdata(a));
    check1(tag, ok, exp_ok());
    @(posedge clk);
    sw = v && !wr && wo_a[cs];
    sr = v && wr && ro_a[cs];
    cw = we && !addr && wdata[29];
    cr = we && !addr && wdata[28];
    if (we && addr) begin
      m_men = wdata[0]; m_ben = wdata[1]; m_bact = wdata[2];
    end
    m_wo = sw || (m_wo && !cw);
    m_ro = sr || (m_ro && !cr);
    if (sw || sr) m_idx = cs;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_wo = 0; m_ro = 0; m_idx = 0; m_men = 0; m_ben = 1; m_bact = 1;
    #(PERIOD*2 + 1);
    // R10 reset values
    addr = 0; #1; check32("R10", rdata, 32'h0);
    addr = 1; #1; check32("R10", rdata, 32'h6);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    step("R7", 0, 1, 0, 1, 3, 0);            // master off: region 3 rejected
    step("R8", 0, 0, 0, 1, 0, 0);            // boot region 0 accepted
    step("R7", 1, 1, 32'h7, 0, 0, 0);        // register write works while disabled
    step("R7", 0, 1, 0, 1, 3, 1);            // master on: accepted
    step("R1", 0, 0, 0, 1, 2, 0);            // read of write-only region 2 (R9 reject)
    step("R1", 0, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 32'h0, 0, 0, 0);        // write 0: no effect
    step("R3", 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 1, 5, 1);            // write to read-only region 5
    step("R4", 0, 0, 0, 0, 0, 0);            // idx now 5, both flags
    step("R3", 1, 0, 32'h2000_0000, 0, 0, 0);// clear write-only flag
    step("R3", 0, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 32'h1000_0000, 1, 5, 1);// clear and set together
    step("R5", 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 7, 0);            // region 7 write-only read
    step("R4", 0, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 32'h3000_0000, 0, 0, 0);
    step("R6", 1, 1, 32'h4, 0, 0, 0);        // boot_act=1, boot_en=0, master=0
    step("R8", 0, 0, 0, 1, 0, 0);            // boot region blocked by its enable
    step("R6", 0, 0, 0, 1, 2, 0);            // violation while disabled
    step("R6", 0, 0, 0, 0, 0, 0);
    step("R8", 1, 1, 32'h1, 0, 0, 0);        // boot_act=0, master=1
    step("R8", 0, 1, 0, 1, 0, 1);            // region 0 follows master
    step("R9", 0, 0, 0, 1, 5, 0);            // legal read of read-only region
    step("R9", 0, 1, 0, 0, 4, 0);            // no access -> not accepted

    for (int i = 0; i < 400; i++) begin
      bit [31:0] r = $urandom;
      logic [31:0] d = {2'b00, r[1:0], 25'h0, r[4:2]};
      step("R4", r[5] & r[6], r[7], d, r[8], r[11:9], r[12]);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule